// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks outstanding misses for a non-blocking cache. A small set of entries is handed out from a free pool. Each entry records a size-aligned line address, a size, a thread tag, a command code and whether it holds an outstanding target. Live entries that are waiting to be sent to the next level sit in a separately kept pending order. The head of that order is presented as the issue candidate. Entries move between the pending and in-service states, can be promoted to the head of the pending order, and return to the pool when they are freed or squashed by thread.

Two lookups run in parallel with everything else. An exact lookup compares a query address against every live entry. An overlap lookup walks the pending order and reports the first entry whose byte range intersects a query range. The block honours one command per cycle, in this priority: squash, free, re-pend, mark in service, promote, allocate. Occupancy counts and a full flag let the cache stall ordinary misses while the reserve entries stay usable.

Top module: `mshr_file`

## Requirements
- R1: The file holds N_MISS + N_RESV - 1 entries (4 with the default parameters). After reset every entry is free, the issue output is invalid and all counters read zero.
- R2: An allocation stores the request address with its low alloc_slog bits cleared. The exact lookup reports a hit, with the lowest matching index, when a live entry's stored address equals lk_addr.
- R3: An allocation with alloc_resp=1 adds one to cnt_tgt. An allocation with alloc_resp=0 makes a buffer entry that adds nothing to cnt_tgt.
- R4: A normally allocated entry joins the tail of the pending order. iss_valid and iss_idx show the head of that order from the cycle after each update.
- R5: After reset the pool hands out index 0 first, then 1, 2 and so on. A freed entry goes on top of the pool, so the most recently freed index is handed out next on alloc_idx.
- R6: Marking a pending buffer entry in service frees it. Marking any other pending entry removes it from the pending order and raises cnt_svc by one.
- R7: A re-pend request on an in-service entry replaces its command with rep_cmd, lowers cnt_svc by one and appends the entry to the tail of the pending order. The issue command output iss_cmd shows the command of the head entry.
- R8: A promote request moves a pending entry to the head of the pending order. A promote request on an in-service entry has no effect.
- R9: The overlap lookup reports the first entry, in pending order, whose range [addr, addr + 2^slog) intersects [ov_addr, ov_addr + 2^ov_slog). Ranges that only touch do not intersect.
- R10: A squash for thread T clears the target of every live entry tagged T. It frees those entries that are not in service and keeps the in-service ones allocated.
- R11: An allocation with alloc_direct=1 enters service at once, never joins the pending order, and adds nothing to cnt_tgt.
- R12: An allocation while no entry is free raises alloc_err in that cycle and changes no state.
- R13: full is 1 when the number of free entries is at or below N_RESV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocate request |
| alloc_addr | input | AW | Request byte address |
| alloc_slog | input | SLW | log2 of the request size in bytes |
| alloc_resp | input | 1 | Request needs a response (counts as a target) |
| alloc_direct | input | 1 | Allocate straight into service, bypassing the pending order |
| alloc_tid | input | TIDW | Thread tag |
| alloc_cmd | input | CMDW | Command code stored with the entry |
| alloc_idx | output | IW | Index the next allocation will take |
| alloc_err | output | 1 | Allocation attempted with the pool empty |
| full | output | 1 | Free entries at or below the reserve |
| svc_valid | input | 1 | Mark an entry in service |
| svc_idx | input | IW | Entry to mark in service |
| rep_valid | input | 1 | Return an in-service entry to pending |
| rep_idx | input | IW | Entry to return |
| rep_cmd | input | CMDW | New command for the returned entry |
| pro_valid | input | 1 | Promote a pending entry to the head |
| pro_idx | input | IW | Entry to promote |
| dealloc_valid | input | 1 | Free an entry |
| dealloc_idx | input | IW | Entry to free |
| squash_valid | input | 1 | Squash by thread |
| squash_tid | input | TIDW | Thread to squash |
| lk_addr | input | AW | Exact lookup address |
| lk_hit | output | 1 | Exact lookup hit |
| lk_idx | output | IW | Lowest matching index |
| ov_addr | input | AW | Overlap query start address |
| ov_slog | input | SLW | log2 of the overlap query size |
| ov_hit | output | 1 | Overlap found among pending entries |
| ov_idx | output | IW | First overlapping entry in pending order |
| iss_valid | output | 1 | A pending entry exists |
| iss_idx | output | IW | Head of the pending order |
| iss_cmd | output | CMDW | Command of the head entry |
| cnt_alloc | output | CW | Live entries |
| cnt_svc | output | CW | Entries in service |
| cnt_tgt | output | CW | Outstanding targets |

## Verification
The hardest situation to reach is a squash that meets a mix of states at once. It needs a pending entry, an in-service entry that still holds a target, a directly allocated entry and an entry of another thread, all live together with the pool drained. The stimulus builds that state step by step. It allocates a direct entry, fills the pool until an allocation is refused, and marks one targeted entry in service. Only then does it squash, and it checks the counters, the issue head and the exact lookup for each survivor. The pending order is reshuffled by promotions and re-pends before the overlap lookup is queried, so the first-in-order rule is tested separately from index order.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
   // One command is honoured per cycle; the order encodes priority.
   typedef enum logic [2:0] {
      OP_NONE,
      OP_SQUASH,
      OP_FREE,
      OP_REPEND,
      OP_SERVICE,
      OP_PROMOTE,
      OP_ALLOC
   } mshr_op_e;
endpackage

// File: rtl/mshr_free_stack.sv
module mshr_free_stack #(
   parameter int E  = 4,
   parameter int IW = 2,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic [E-1:0]  push_mask,
   output logic [IW-1:0] top_idx,
   output logic          empty
);
   logic [IW-1:0] stk   [E];
   logic [IW-1:0] stk_n [E];
   logic [CW-1:0] cnt, cnt_n;

   always_comb begin
      stk_n = stk;
      cnt_n = cnt;
      if (pop && cnt != '0) cnt_n = cnt - 1'b1;
      for (int i = 0; i < E; i++) begin
         if (push_mask[i] && cnt_n < CW'(E)) begin
            stk_n[IW'(cnt_n)] = IW'(i);
            cnt_n = cnt_n + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < E; k++) stk[k] <= IW'(E - 1 - k);
         cnt <= CW'(E);
      end else begin
         stk <= stk_n;
         cnt <= cnt_n;
      end
   end

   assign empty   = (cnt == '0);
   assign top_idx = empty ? '0 : stk[IW'(cnt - 1'b1)];

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(E));
   assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt != '0);
endmodule

// File: rtl/mshr_pend_list.sv
module mshr_pend_list #(
   parameter int E  = 4,
   parameter int IW = 2,
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [E-1:0]  rm_mask,
   input  logic          app_v,
   input  logic [IW-1:0] app_idx,
   input  logic          pre_v,
   input  logic [IW-1:0] pre_idx,
   output logic [IW-1:0] order [E],
   output logic [CW-1:0] len,
   output logic          head_v,
   output logic [IW-1:0] head_idx
);
   logic [IW-1:0] lst_n [E];
   logic [CW-1:0] len_n;

   // Compact out removed indices, then optionally insert at head or tail.
   always_comb begin
      for (int i = 0; i < E; i++) lst_n[i] = '0;
      len_n = '0;
      for (int i = 0; i < E; i++) begin
         if (CW'(i) < len && !rm_mask[order[i]]) begin
            lst_n[IW'(len_n)] = order[i];
            len_n = len_n + 1'b1;
         end
      end
      if (pre_v && len_n < CW'(E)) begin
         for (int i = E - 1; i > 0; i--) lst_n[i] = lst_n[i-1];
         lst_n[0] = pre_idx;
         len_n = len_n + 1'b1;
      end
      if (app_v && len_n < CW'(E)) begin
         lst_n[IW'(len_n)] = app_idx;
         len_n = len_n + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < E; k++) order[k] <= '0;
         len <= '0;
      end else begin
         order <= lst_n;
         len   <= len_n;
      end
   end

   assign head_v   = (len != '0);
   assign head_idx = order[0];

   assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      len <= CW'(E));
   assert_append_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      app_v |=> head_v);
   assert_promote_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pre_v |=> head_idx == $past(pre_idx));
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
   parameter int E   = 4,
   parameter int AW  = 16,
   parameter int SLW = 3,
   parameter int IW  = 2,
   parameter int CW  = 3
) (
   input  logic [E-1:0]   ent_v,
   input  logic [AW-1:0]  ent_addr [E],
   input  logic [SLW-1:0] ent_slog [E],
   input  logic [IW-1:0]  pend_order [E],
   input  logic [CW-1:0]  pend_len,
   input  logic [AW-1:0]  lk_addr,
   input  logic [AW-1:0]  ov_addr,
   input  logic [SLW-1:0] ov_slog,
   output logic           lk_hit,
   output logic [IW-1:0]  lk_idx,
   output logic           ov_hit,
   output logic [IW-1:0]  ov_idx
);
   localparam logic [AW:0] ONE = (AW+1)'(1);

   // Exact match: scan downward so the lowest index wins.
   always_comb begin
      lk_hit = 1'b0;
      lk_idx = '0;
      for (int i = E - 1; i >= 0; i--) begin
         if (ent_v[i] && ent_addr[i] == lk_addr) begin
            lk_hit = 1'b1;
            lk_idx = IW'(i);
         end
      end
   end

   // Overlap: scan the pending order backwards so the earliest position wins.
   always_comb begin
      logic [AW:0] q_lo, q_hi;
      q_lo   = {1'b0, ov_addr};
      q_hi   = q_lo + (ONE << ov_slog);
      ov_hit = 1'b0;
      ov_idx = '0;
      for (int i = E - 1; i >= 0; i--) begin
         logic [IW-1:0] e;
         logic [AW:0]   lo, hi;
         e  = pend_order[i];
         lo = {1'b0, ent_addr[e]};
         hi = lo + (ONE << ent_slog[e]);
         if (CW'(i) < pend_len && lo < q_hi && q_lo < hi) begin
            ov_hit = 1'b1;
            ov_idx = e;
         end
      end
   end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
   import mshr_pkg::*;
#(
   parameter int N_MISS = 4,
   parameter int N_RESV = 1,
   parameter int AW     = 16,
   parameter int SLW    = 3,
   parameter int TIDW   = 1,
   parameter int CMDW   = 2,
   localparam int E     = N_MISS + N_RESV - 1,
   localparam int IW    = (E > 1) ? $clog2(E) : 1,
   localparam int CW    = $clog2(E + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_valid,
   input  logic [AW-1:0]   alloc_addr,
   input  logic [SLW-1:0]  alloc_slog,
   input  logic            alloc_resp,
   input  logic            alloc_direct,
   input  logic [TIDW-1:0] alloc_tid,
   input  logic [CMDW-1:0] alloc_cmd,
   output logic [IW-1:0]   alloc_idx,
   output logic            alloc_err,
   output logic            full,
   input  logic            svc_valid,
   input  logic [IW-1:0]   svc_idx,
   input  logic            rep_valid,
   input  logic [IW-1:0]   rep_idx,
   input  logic [CMDW-1:0] rep_cmd,
   input  logic            pro_valid,
   input  logic [IW-1:0]   pro_idx,
   input  logic            dealloc_valid,
   input  logic [IW-1:0]   dealloc_idx,
   input  logic            squash_valid,
   input  logic [TIDW-1:0] squash_tid,
   input  logic [AW-1:0]   lk_addr,
   output logic            lk_hit,
   output logic [IW-1:0]   lk_idx,
   input  logic [AW-1:0]   ov_addr,
   input  logic [SLW-1:0]  ov_slog,
   output logic            ov_hit,
   output logic [IW-1:0]   ov_idx,
   output logic            iss_valid,
   output logic [IW-1:0]   iss_idx,
   output logic [CMDW-1:0] iss_cmd,
   output logic [CW-1:0]   cnt_alloc,
   output logic [CW-1:0]   cnt_svc,
   output logic [CW-1:0]   cnt_tgt
);
   // Elaboration-time parameter checks
   if (N_MISS < 1 || N_RESV < 1) begin : g_chk_counts
      $error("mshr_file: N_MISS and N_RESV must be at least 1");
   end
   if (E < 2) begin : g_chk_depth
      $error("mshr_file: at least two entries are required");
   end
   if ((1 << SLW) - 1 >= AW) begin : g_chk_size
      $error("mshr_file: SLW allows sizes wider than the address");
   end

   logic [E-1:0]    e_v, e_svc, e_buf, e_tgt, pend;
   logic [AW-1:0]   e_addr [E];
   logic [SLW-1:0]  e_slog [E];
   logic [TIDW-1:0] e_tid  [E];
   logic [CMDW-1:0] e_cmd  [E];

   mshr_op_e       op;
   logic           pool_empty, alloc_ok, svc_ok, rep_ok, pro_ok;
   logic [IW-1:0]  top_idx;
   logic [E-1:0]   sq_mask, free_mask, rm_mask;
   logic [IW-1:0]  p_order [E];
   logic [CW-1:0]  p_len;
   logic [AW-1:0]  alloc_aligned;

   assign pend = e_v & ~e_svc;

   always_comb begin
      if      (squash_valid)  op = OP_SQUASH;
      else if (dealloc_valid) op = OP_FREE;
      else if (rep_valid)     op = OP_REPEND;
      else if (svc_valid)     op = OP_SERVICE;
      else if (pro_valid)     op = OP_PROMOTE;
      else if (alloc_valid)   op = OP_ALLOC;
      else                    op = OP_NONE;
   end

   assign alloc_ok  = (op == OP_ALLOC) && !pool_empty;
   assign alloc_err = (op == OP_ALLOC) &&  pool_empty;
   assign svc_ok    = (op == OP_SERVICE) && pend[svc_idx];
   assign rep_ok    = (op == OP_REPEND) && e_v[rep_idx] && e_svc[rep_idx];
   assign pro_ok    = (op == OP_PROMOTE) && pend[pro_idx];
   assign alloc_aligned = alloc_addr & ~((AW'(1) << alloc_slog) - AW'(1));

   always_comb begin
      for (int i = 0; i < E; i++) begin
         sq_mask[i]   = (op == OP_SQUASH) && e_v[i] && (e_tid[i] == squash_tid);
         free_mask[i] = ((op == OP_FREE) && dealloc_idx == IW'(i) && e_v[i])
                     || (svc_ok && svc_idx == IW'(i) && e_buf[i])
                     || (sq_mask[i] && !e_svc[i]);
         rm_mask[i]   = pend[i] && (free_mask[i]
                     || (svc_ok && svc_idx == IW'(i))
                     || (pro_ok && pro_idx == IW'(i)));
      end
   end

   mshr_free_stack #(.E(E), .IW(IW), .CW(CW)) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop       (alloc_ok),
      .push_mask (free_mask),
      .top_idx   (top_idx),
      .empty     (pool_empty)
   );

   mshr_pend_list #(.E(E), .IW(IW), .CW(CW)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .rm_mask  (rm_mask),
      .app_v    ((alloc_ok && !alloc_direct) || rep_ok),
      .app_idx  (rep_ok ? rep_idx : top_idx),
      .pre_v    (pro_ok),
      .pre_idx  (pro_idx),
      .order    (p_order),
      .len      (p_len),
      .head_v   (iss_valid),
      .head_idx (iss_idx)
   );

   mshr_match #(.E(E), .AW(AW), .SLW(SLW), .IW(IW), .CW(CW)) u_match (
      .ent_v      (e_v),
      .ent_addr   (e_addr),
      .ent_slog   (e_slog),
      .pend_order (p_order),
      .pend_len   (p_len),
      .lk_addr    (lk_addr),
      .ov_addr    (ov_addr),
      .ov_slog    (ov_slog),
      .lk_hit     (lk_hit),
      .lk_idx     (lk_idx),
      .ov_hit     (ov_hit),
      .ov_idx     (ov_idx)
   );

   // Per-entry state
   for (genvar g = 0; g < E; g++) begin : g_ent
      logic            v, svc, bf, tgt;
      logic [AW-1:0]   addr;
      logic [SLW-1:0]  slog;
      logic [TIDW-1:0] tid;
      logic [CMDW-1:0] cmd;
      logic            take;

      assign take = alloc_ok && (top_idx == IW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0; svc <= 1'b0; bf <= 1'b0; tgt <= 1'b0;
            addr <= '0; slog <= '0; tid <= '0; cmd <= '0;
         end else if (free_mask[g]) begin
            v <= 1'b0; svc <= 1'b0; bf <= 1'b0; tgt <= 1'b0;
         end else if (take) begin
            v    <= 1'b1;
            svc  <= alloc_direct;
            bf   <= !alloc_resp && !alloc_direct;
            tgt  <= alloc_resp && !alloc_direct;
            addr <= alloc_aligned;
            slog <= alloc_slog;
            tid  <= alloc_tid;
            cmd  <= alloc_cmd;
         end else begin
            if (svc_ok && svc_idx == IW'(g)) svc <= 1'b1;
            if (rep_ok && rep_idx == IW'(g)) begin
               svc <= 1'b0;
               cmd <= rep_cmd;
            end
            if (sq_mask[g]) tgt <= 1'b0;
         end
      end

      assign e_v[g]    = v;
      assign e_svc[g]  = svc;
      assign e_buf[g]  = bf;
      assign e_tgt[g]  = tgt;
      assign e_addr[g] = addr;
      assign e_slog[g] = slog;
      assign e_tid[g]  = tid;
      assign e_cmd[g]  = cmd;
   end

   assign alloc_idx = top_idx;
   assign iss_cmd   = e_cmd[iss_idx];
   assign cnt_alloc = CW'($countones(e_v));
   assign cnt_svc   = CW'($countones(e_v & e_svc));
   assign cnt_tgt   = CW'($countones(e_tgt));
   assign full      = (E - int'(cnt_alloc)) <= N_RESV;

   // Assertions
   assert_svc_le_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_svc <= cnt_alloc);
   assert_issue_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (e_v[iss_idx] && !e_svc[iss_idx]));
   assert_buffer_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ok && e_buf[svc_idx]) |=> !e_v[$past(svc_idx)]);
   assert_repend_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rep_ok |=> (iss_valid && !e_svc[$past(rep_idx)]));
   assert_err_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |=> $stable(e_v));
   assert_lookup_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (e_v[lk_idx] && e_addr[lk_idx] == lk_addr));
   assert_squash_spares_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SQUASH) |=> (($past(e_v & e_svc) & ~e_v) == '0));
   assert_direct_service_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ok && alloc_direct) |=> e_svc[$past(top_idx)]);
endmodule

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        alloc_valid, alloc_resp, alloc_direct;
   logic [15:0] alloc_addr;
   logic [2:0]  alloc_slog;
   logic [0:0]  alloc_tid;
   logic [1:0]  alloc_cmd;
   logic [1:0]  alloc_idx;
   logic        alloc_err, full;
   logic        svc_valid, rep_valid, pro_valid, dealloc_valid, squash_valid;
   logic [1:0]  svc_idx, rep_idx, pro_idx, dealloc_idx;
   logic [1:0]  rep_cmd;
   logic [0:0]  squash_tid;
   logic [15:0] lk_addr, ov_addr;
   logic [2:0]  ov_slog;
   logic        lk_hit, ov_hit, iss_valid;
   logic [1:0]  lk_idx, ov_idx, iss_idx, iss_cmd;
   logic [2:0]  cnt_alloc, cnt_svc, cnt_tgt;

   always #10 clk = ~clk;   // 50 MHz

   mshr_file u0 (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam int A = 1, S = 2, RP = 3, P = 4, D = 5, Q = 6;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  idx;
      logic [15:0] addr;
      logic        resp;
      logic        tid;
      logic        ev;
      logic [1:0]  ei;
      logic [2:0]  ea;
      logic [2:0]  es;
      logic [2:0]  et;
   } vec_t;

   // op idx addr resp tid | iss_valid iss_idx cnt_alloc cnt_svc cnt_tgt
   localparam vec_t TBL [12] = '{
      '{3'd1, 2'd0, 16'h1234, 1'b1, 1'b0, 1'b1, 2'd0, 3'd1, 3'd0, 3'd1}, // R3 R4
      '{3'd1, 2'd0, 16'h2000, 1'b1, 1'b1, 1'b1, 2'd0, 3'd2, 3'd0, 3'd2},
      '{3'd1, 2'd0, 16'h3000, 1'b0, 1'b0, 1'b1, 2'd0, 3'd3, 3'd0, 3'd2}, // R3 buffer
      '{3'd2, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd3, 3'd1, 3'd2}, // R6
      '{3'd4, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd2, 3'd3, 3'd1, 3'd2}, // R8
      '{3'd2, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 3'd1, 3'd2}, // R6 buffer frees
      '{3'd3, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 3'd0, 3'd2}, // R7 tail
      '{3'd4, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 3'd2, 3'd0, 3'd2}, // R8
      '{3'd5, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd0, 3'd1, 3'd0, 3'd1},
      '{3'd1, 2'd0, 16'h4000, 1'b1, 1'b1, 1'b1, 2'd0, 3'd2, 3'd0, 3'd2}, // R5 reuses 1
      '{3'd4, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd1, 3'd2, 3'd0, 3'd2},
      '{3'd6, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd0, 3'd1, 3'd0, 3'd1}  // R10
   };

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 1'b0; svc_valid = 1'b0; rep_valid = 1'b0;
      pro_valid = 1'b0; dealloc_valid = 1'b0; squash_valid = 1'b0;
   endtask

   // Drive one command after a falling edge; result is visible one clock later.
   task automatic setup(int code, int idx, int addr, int resp, int tid,
                        int slog, int cmd, int direct);
      @(negedge clk);
      idle();
      case (code)
         A: begin
            alloc_valid = 1'b1; alloc_addr = 16'(addr); alloc_resp = 1'(resp);
            alloc_tid = 1'(tid); alloc_slog = 3'(slog); alloc_cmd = 2'(cmd);
            alloc_direct = 1'(direct);
         end
         S:  begin svc_valid = 1'b1; svc_idx = 2'(idx); end
         RP: begin rep_valid = 1'b1; rep_idx = 2'(idx); rep_cmd = 2'(cmd); end
         P:  begin pro_valid = 1'b1; pro_idx = 2'(idx); end
         D:  begin dealloc_valid = 1'b1; dealloc_idx = 2'(idx); end
         Q:  begin squash_valid = 1'b1; squash_tid = 1'(tid); end
         default: ;
      endcase
      #1;
   endtask

   task automatic finish_op();
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic run(int code, int idx, int addr, int resp, int tid,
                      int slog, int cmd, int direct);
      setup(code, idx, addr, resp, tid, slog, cmd, direct);
      finish_op();
   endtask

   task automatic look(int addr, int exp_hit, int exp_idx, string req);
      lk_addr = 16'(addr);
      #1;
      chk({req, " exact hit"}, int'(lk_hit), exp_hit);
      if (exp_hit != 0) chk({req, " exact idx"}, int'(lk_idx), exp_idx);
   endtask

   task automatic ovl(int addr, int slog, int exp_hit, int exp_idx, string req);
      ov_addr = 16'(addr);
      ov_slog = 3'(slog);
      #1;
      chk({req, " overlap hit"}, int'(ov_hit), exp_hit);
      if (exp_hit != 0) chk({req, " overlap idx"}, int'(ov_idx), exp_idx);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      idle();
      alloc_addr = '0; alloc_resp = 1'b0; alloc_direct = 1'b0; alloc_tid = '0;
      alloc_slog = '0; alloc_cmd = '0; svc_idx = '0; rep_idx = '0; rep_cmd = '0;
      pro_idx = '0; dealloc_idx = '0; squash_tid = '0;
      lk_addr = '0; ov_addr = '0; ov_slog = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 / R5 reset state
      chk("R1 reset iss_valid", int'(iss_valid), 0);
      chk("R1 reset cnt_alloc", int'(cnt_alloc), 0);
      chk("R1 reset cnt_svc", int'(cnt_svc), 0);
      chk("R1 reset cnt_tgt", int'(cnt_tgt), 0);
      chk("R13 reset full", int'(full), 0);
      chk("R5 reset first index", int'(alloc_idx), 0);

      // Vector table walk (slog 4, cmd 1, re-pend cmd 2)
      for (int r = 0; r < 12; r++) begin
         run(int'(TBL[r].op), int'(TBL[r].idx), int'(TBL[r].addr),
             int'(TBL[r].resp), int'(TBL[r].tid), 4,
             (TBL[r].op == 3'd3) ? 2 : 1, 0);
         chk($sformatf("R4 row%0d iss_valid", r), int'(iss_valid), int'(TBL[r].ev));
         chk($sformatf("R4 row%0d iss_idx", r), int'(iss_idx), int'(TBL[r].ei));
         chk($sformatf("R3 row%0d cnt_alloc", r), int'(cnt_alloc), int'(TBL[r].ea));
         chk($sformatf("R6 row%0d cnt_svc", r), int'(cnt_svc), int'(TBL[r].es));
         chk($sformatf("R3 row%0d cnt_tgt", r), int'(cnt_tgt), int'(TBL[r].et));
      end

      // R2: stored address is aligned (0x1234 with 16-byte size -> 0x1230)
      look(16'h1230, 1, 0, "R2");
      look(16'h1234, 0, 0, "R2");
      look(16'h2000, 0, 0, "R10 squashed thread");

      // R9: byte-range overlap against pending entry 0 [0x1230,0x1240)
      ovl(16'h123c, 2, 1, 0, "R9 inside");
      ovl(16'h1240, 2, 0, 0, "R9 touching above");
      ovl(16'h1220, 4, 0, 0, "R9 touching below");
      ovl(16'h1228, 4, 1, 0, "R9 straddle");

      // R5 + R11: direct allocation takes the most recently freed index 1
      setup(A, 0, 16'h5000, 1, 0, 4, 2, 1);
      chk("R5 lifo reuse idx", int'(alloc_idx), 1);
      finish_op();
      chk("R11 direct not pending iss_idx", int'(iss_idx), 0);
      chk("R11 direct cnt_svc", int'(cnt_svc), 1);
      chk("R11 direct cnt_tgt", int'(cnt_tgt), 1);
      look(16'h5000, 1, 1, "R11");

      // R13 full threshold
      chk("R13 two free not full", int'(full), 0);
      setup(A, 0, 16'h1238, 1, 0, 3, 1, 0);
      chk("R5 next idx", int'(alloc_idx), 2);
      finish_op();
      chk("R13 one free full", int'(full), 1);
      chk("R3 cnt_tgt", int'(cnt_tgt), 2);

      // R9 first in pending order, then reordered by promote (R8)
      ovl(16'h123c, 2, 1, 0, "R9 order before promote");
      run(P, 2, 0, 0, 0, 0, 0, 0);
      chk("R8 promoted head", int'(iss_idx), 2);
      ovl(16'h123c, 2, 1, 2, "R9 order after promote");

      // Drain the pool, then R12 allocation refused
      run(A, 0, 16'h7000, 0, 1, 4, 1, 0);
      chk("R1 four entries live", int'(cnt_alloc), 4);
      setup(A, 0, 16'h8000, 1, 0, 4, 1, 0);
      chk("R12 alloc_err raised", int'(alloc_err), 1);
      finish_op();
      chk("R12 alloc_err clears", int'(alloc_err), 0);
      chk("R12 count unchanged", int'(cnt_alloc), 4);
      look(16'h8000, 0, 0, "R12");

      // R10: squash thread 0 with a mix of states
      run(S, 2, 0, 0, 0, 0, 0, 0);
      chk("R6 cnt_svc", int'(cnt_svc), 2);
      chk("R6 removed from pending", int'(iss_idx), 0);
      run(Q, 0, 0, 0, 0, 0, 0, 0);
      chk("R10 cnt_alloc", int'(cnt_alloc), 3);
      chk("R10 cnt_svc", int'(cnt_svc), 2);
      chk("R10 targets cleared", int'(cnt_tgt), 0);
      chk("R10 iss_idx other thread", int'(iss_idx), 3);
      look(16'h1238, 1, 2, "R10 in-service spared");
      look(16'h1230, 0, 0, "R10 pending freed");

      // R7: re-pend with new command goes to tail
      run(RP, 2, 0, 0, 0, 0, 3, 0);
      chk("R7 cnt_svc", int'(cnt_svc), 1);
      chk("R7 tail keeps head", int'(iss_idx), 3);
      run(S, 3, 0, 0, 0, 0, 0, 0);
      chk("R6 buffer freed", int'(cnt_alloc), 2);
      chk("R7 head after", int'(iss_idx), 2);
      chk("R7 new command", int'(iss_cmd), 3);

      // R8: promote of an in-service entry ignored
      run(P, 1, 0, 0, 0, 0, 0, 0);
      chk("R8 ignored head", int'(iss_idx), 2);
      chk("R8 ignored cnt_svc", int'(cnt_svc), 1);
      chk("R8 ignored valid", int'(iss_valid), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule